// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block holds the control word of one DMA channel, together with the channel's source-address pointer and its transfer counter. It decides when the channel may move a datum. Requests come from three places: an external source-side request, an external destination-side request, and an internal timer request. The control word picks which of them applies. When the channel is started and the selected request is present, the block raises a transfer strobe for that cycle. At the following clock edge it steps the source pointer and decrements the counter.

Termination depends on the synchronisation mode. A free-running (unsynchronised) channel always stops when its count reaches zero. A request-synchronised channel stops at zero only when its terminal-count bit is set. Otherwise its counter wraps and transfers go on. When the channel stops, it gives a one-cycle done pulse and clears its own start bit. It can also give an interrupt pulse. The bus cycles, the destination pointer and arbitration between channels are outside the block. It exports one priority flag for an external arbiter.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the control word reads 0x00C0: synchronisation field 11, every other bit 0. The strobe, done, interrupt, priority and word outputs are all 0.
- R2: A control write changes the start bit (bit 1) only when bit 2 of the same written word is 1. Bit 2 always reads back 0. The remaining bits are stored as written.
- R3: The strobe is high only while the start bit is 1 and the selected request is high. With bit 4 = 1 only `tmr_req` counts, whatever bits 7:6 hold. With bit 4 = 0 the timer request is blocked, and bits 7:6 select the request: 00 always requesting, 01 `src_req`, 10 `dst_req`, 11 never.
- R4: On a transfer the source pointer goes up when bit 10 = 1 and bit 11 = 0, and down when bit 11 = 1 and bit 10 = 0. When the two bits are equal it holds.
- R5: The pointer step is 1 when bit 0 = 0 (byte) and 2 when bit 0 = 1 (word). The `word_xfer` output mirrors bit 0.
- R6: Each transfer decrements the counter by one, modulo 2^CNT_W.
- R7: In unsynchronised mode, a transfer that brings the count from 1 to 0 ends the run whatever bit 9 holds. The next cycle shows a one-cycle `done` pulse, the start bit reads 0 and the strobe stays low.
- R8: In a synchronised mode (source, destination or timer), a transfer from count 1 to 0 ends the run only if bit 9 = 1. With bit 9 = 0 no done pulse occurs, the counter wraps to all ones and transfers continue.
- R9: `irq` pulses together with `done` only when bit 8 and bit 9 are both 1.
- R10: `hi_pri` mirrors bit 5 of the control word.
- R11: A write that clears the start bit (bit 2 = 1, bit 1 = 0) stops the strobe from the next cycle on, and the counter then holds.
- R12: Bit 3 is stored and read back but changes neither request selection nor pointer stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctl | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control word to write |
| ctl_rd | output | 16 | Control word read-back |
| wr_src | input | 1 | Source pointer load strobe |
| src_wdata | input | ADDR_W | Source pointer load value |
| wr_cnt | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| src_req | input | 1 | External source-side request |
| dst_req | input | 1 | External destination-side request |
| tmr_req | input | 1 | Internal timer request |
| xfer_stb | output | 1 | A transfer happens this cycle |
| src_addr | output | ADDR_W | Current source pointer |
| word_xfer | output | 1 | 1 for word transfers, 0 for byte |
| cnt_val | output | CNT_W | Current transfer count |
| done | output | 1 | One-cycle pulse when a run ends |
| irq | output | 1 | One-cycle interrupt request pulse |
| hi_pri | output | 1 | Relative priority flag for the arbiter |

## Verification
The strobe, `word_xfer` and `hi_pri` are combinational from the registers and the request pins. They are checked one time unit after inputs change, in the same cycle. The pointer, the counter, the control read-back, `done` and `irq` are registered, so each of them is checked one time unit after the edge that consumed the stimulus. For a run ending at count 1, that means `done` is checked right after the edge of the final transfer, and again one edge later to confirm it is a single pulse. All sampling stays one time unit past the rising edge, where no register is changing.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int CTL_W = 16;

    // control word bit positions
    localparam int B_WORD  = 0;
    localparam int B_START = 1;
    localparam int B_CHG   = 2;
    localparam int B_SPARE = 3;
    localparam int B_TMR   = 4;
    localparam int B_PRI   = 5;
    localparam int B_SYNC  = 6;
    localparam int B_INT   = 8;
    localparam int B_TC    = 9;
    localparam int B_INC   = 10;
    localparam int B_DEC   = 11;

    localparam logic [CTL_W-1:0] CTL_RST = 16'h00C0;

    typedef enum logic [1:0] {
        SYNC_FREE = 2'b00,
        SYNC_SRC  = 2'b01,
        SYNC_DST  = 2'b10,
        SYNC_RSVD = 2'b11
    } sync_e;

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
    import dma_chan_pkg::*;
(
    input  sync_e mode,
    input  logic  tmr_en,
    input  logic  src_req,
    input  logic  dst_req,
    input  logic  tmr_req,
    output logic  req,
    output logic  free_run
);
    always_comb begin
        free_run = 1'b0;
        if (tmr_en) begin
            req = tmr_req;
        end else begin
            unique case (mode)
                SYNC_FREE: begin
                    req      = 1'b1;
                    free_run = 1'b1;
                end
                SYNC_SRC:  req = src_req;
                SYNC_DST:  req = dst_req;
                default:   req = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              inc,
    input  logic              dec,
    input  logic              word,
    output logic [ADDR_W-1:0] addr_nxt
);
    localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = word ? STEP_W : STEP_B;
        if (inc && !dec)
            addr_nxt = addr + step;
        else if (dec && !inc)
            addr_nxt = addr - step;
        else
            addr_nxt = addr;
    end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_ctl,
    input  logic [CTL_W-1:0]        wr_data,
    output logic [CTL_W-1:0]        ctl_rd,
    input  logic                    wr_src,
    input  logic [ADDR_W-1:0]       src_wdata,
    input  logic                    wr_cnt,
    input  logic [CNT_W-1:0]        cnt_wdata,
    input  logic                    src_req,
    input  logic                    dst_req,
    input  logic                    tmr_req,
    output logic                    xfer_stb,
    output logic [ADDR_W-1:0]       src_addr,
    output logic                    word_xfer,
    output logic [CNT_W-1:0]        cnt_val,
    output logic                    done,
    output logic                    irq,
    output logic                    hi_pri
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [ADDR_W-1:0] src;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              irq;
    } state_t;

    state_t s_d, s_q;

    logic              req_sel;
    logic              free_run;
    logic              xfer;
    logic              term;
    logic [ADDR_W-1:0] src_step;
    logic [CTL_W-1:0]  ctl_wr;

    dma_req_sel u_req (
        .mode     (sync_e'(s_q.ctl[B_SYNC+1:B_SYNC])),
        .tmr_en   (s_q.ctl[B_TMR]),
        .src_req  (src_req),
        .dst_req  (dst_req),
        .tmr_req  (tmr_req),
        .req      (req_sel),
        .free_run (free_run)
    );

    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .addr     (s_q.src),
        .inc      (s_q.ctl[B_INC]),
        .dec      (s_q.ctl[B_DEC]),
        .word     (s_q.ctl[B_WORD]),
        .addr_nxt (src_step)
    );

    always_comb begin
        xfer = s_q.ctl[B_START] && req_sel;
        term = xfer && (s_q.cnt == CNT_ONE) && (free_run || s_q.ctl[B_TC]);

        ctl_wr          = wr_data;
        ctl_wr[B_CHG]   = 1'b0;
        ctl_wr[B_START] = wr_data[B_CHG] ? wr_data[B_START] : s_q.ctl[B_START];

        s_d      = s_q;
        s_d.done = term;
        s_d.irq  = term && s_q.ctl[B_INT] && s_q.ctl[B_TC];

        if (wr_ctl)
            s_d.ctl = ctl_wr;
        else if (term)
            s_d.ctl[B_START] = 1'b0;

        if (wr_src)
            s_d.src = src_wdata;
        else if (xfer)
            s_d.src = src_step;

        if (wr_cnt)
            s_d.cnt = cnt_wdata;
        else if (xfer)
            s_d.cnt = s_q.cnt - CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctl  <= CTL_RST;
            s_q.src  <= '0;
            s_q.cnt  <= '0;
            s_q.done <= 1'b0;
            s_q.irq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_rd    = s_q.ctl;
    assign xfer_stb  = xfer;
    assign src_addr  = s_q.src;
    assign word_xfer = s_q.ctl[B_WORD];
    assign cnt_val   = s_q.cnt;
    assign done      = s_q.done;
    assign irq       = s_q.irq;
    assign hi_pri    = s_q.ctl[B_PRI];

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctl,
    input logic              wr_chg,
    input logic              wr_start,
    input logic              wr_src,
    input logic              wr_cnt,
    input logic              xfer_stb,
    input logic              start_bit,
    input logic              tmr_bit,
    input logic [1:0]        sync_bits,
    input logic              tc_bit,
    input logic              inc_bit,
    input logic              dec_bit,
    input logic [ADDR_W-1:0] src_addr,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              done,
    input logic              irq
);
    // R3: no strobe without the start bit
    p_stb_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> start_bit);

    // R3: reserved mode without timer never transfers
    p_rsvd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bits == 2'b11 && !tmr_bit) |-> !xfer_stb);

    // R4: equal step bits hold the pointer
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !wr_src && inc_bit == dec_bit) |=> $stable(src_addr));

    // R6: one decrement per transfer
    p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !wr_cnt) |=> (cnt_val == $past(cnt_val) - 1'b1));

    // R7: free-running run ends at zero and drops start
    p_free_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && cnt_val == 1 && !wr_ctl && !tmr_bit && sync_bits == 2'b00)
        |=> (done && !start_bit));

    // R8: synchronised without terminal count never ends
    p_sync_notc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !tc_bit && (tmr_bit || sync_bits != 2'b00)) |=> !done);

    // R9: interrupt only alongside done
    p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    // R11: stop write halts the strobe next cycle
    p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_chg && !wr_start) |=> !xfer_stb);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl),
    .wr_chg    (wr_data[2]),
    .wr_start  (wr_data[1]),
    .wr_src    (wr_src),
    .wr_cnt    (wr_cnt),
    .xfer_stb  (xfer_stb),
    .start_bit (ctl_rd[1]),
    .tmr_bit   (ctl_rd[4]),
    .sync_bits (ctl_rd[7:6]),
    .tc_bit    (ctl_rd[9]),
    .inc_bit   (ctl_rd[10]),
    .dec_bit   (ctl_rd[11]),
    .src_addr  (src_addr),
    .cnt_val   (cnt_val),
    .done      (done),
    .irq       (irq)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 16;
    localparam int NVEC   = 15;

    // {ctl[15:0], src_req, dst_req, tmr_req, exp_stb, exp_addr[19:0], exp_cnt[15:0]}
    // start pointer 0x00100, start count 5
    localparam logic [55:0] VEC [NVEC] = '{
        {16'h0400, 3'b000, 1'b1, 20'h00101, 16'd4},  // inc byte free
        {16'h0401, 3'b000, 1'b1, 20'h00102, 16'd4},  // inc word
        {16'h0800, 3'b000, 1'b1, 20'h000FF, 16'd4},  // dec byte
        {16'h0801, 3'b000, 1'b1, 20'h000FE, 16'd4},  // dec word
        {16'h0C01, 3'b000, 1'b1, 20'h00100, 16'd4},  // both set: hold
        {16'h0001, 3'b000, 1'b1, 20'h00100, 16'd4},  // none set: hold
        {16'h0440, 3'b100, 1'b1, 20'h00101, 16'd4},  // src sync, src req
        {16'h0440, 3'b010, 1'b0, 20'h00100, 16'd5},  // src sync, dst req only
        {16'h0480, 3'b010, 1'b1, 20'h00101, 16'd4},  // dst sync, dst req
        {16'h0480, 3'b100, 1'b0, 20'h00100, 16'd5},  // dst sync, src req only
        {16'h04C0, 3'b110, 1'b0, 20'h00100, 16'd5},  // reserved
        {16'h04D0, 3'b001, 1'b1, 20'h00101, 16'd4},  // timer overrides field
        {16'h0410, 3'b110, 1'b0, 20'h00100, 16'd5},  // timer mode ignores free field
        {16'h0440, 3'b001, 1'b0, 20'h00100, 16'd5},  // timer blocked
        {16'h0408, 3'b000, 1'b1, 20'h00101, 16'd4}   // spare bit inert
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_ctl = 1'b0;
    logic [15:0]       wr_data = '0;
    logic [15:0]       ctl_rd;
    logic              wr_src = 1'b0;
    logic [ADDR_W-1:0] src_wdata = '0;
    logic              wr_cnt = 1'b0;
    logic [CNT_W-1:0]  cnt_wdata = '0;
    logic              src_req = 1'b0, dst_req = 1'b0, tmr_req = 1'b0;
    logic              xfer_stb, word_xfer, done, irq, hi_pri;
    logic [ADDR_W-1:0] src_addr;
    logic [CNT_W-1:0]  cnt_val;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_chan_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_data(wr_data), .ctl_rd(ctl_rd),
        .wr_src(wr_src), .src_wdata(src_wdata), .wr_cnt(wr_cnt), .cnt_wdata(cnt_wdata),
        .src_req(src_req), .dst_req(dst_req), .tmr_req(tmr_req), .xfer_stb(xfer_stb),
        .src_addr(src_addr), .word_xfer(word_xfer), .cnt_val(cnt_val), .done(done),
        .irq(irq), .hi_pri(hi_pri)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wctl(input logic [15:0] d);
        wr_ctl  = 1'b1;
        wr_data = d;
        tick();
        wr_ctl  = 1'b0;
    endtask

    // load word (start off), pointer and count, then start
    task automatic setup(input logic [15:0] c, input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n);
        wr_ctl = 1'b1; wr_data = c | 16'h0004;
        wr_src = 1'b1; src_wdata = a;
        wr_cnt = 1'b1; cnt_wdata = n;
        tick();
        wr_src = 1'b0; wr_cnt = 1'b0;
        wr_data = c | 16'h0006;
        tick();
        wr_ctl = 1'b0;
    endtask

    task automatic halt;
        src_req = 1'b0; dst_req = 1'b0; tmr_req = 1'b0;
        wctl(16'h00C4);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctl", 32'(ctl_rd), 32'h00C0);
        chk("R1 outs", {27'd0, xfer_stb, done, irq, hi_pri, word_xfer}, 32'd0);

        // table of request-selection and stepping vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [55:0] v;
            v = VEC[i];
            setup(v[55:40], 20'h00100, 16'd5);
            {src_req, dst_req, tmr_req} = v[39:37];
            #1;
            chk($sformatf("vec%0d strobe R3", i), 32'(xfer_stb), 32'(v[36]));
            tick();
            chk($sformatf("vec%0d addr R4 R5 R12", i), 32'(src_addr), 32'(v[35:16]));
            chk($sformatf("vec%0d count R6", i), 32'(cnt_val), 32'(v[15:0]));
            halt();
        end

        // R2 start gated by change bit, change bit reads 0
        wctl(16'h00C2);
        chk("R2 no chg", 32'(ctl_rd), 32'h00C0);
        wctl(16'h00C6);
        chk("R2 chg set", 32'(ctl_rd), 32'h00C2);
        wctl(16'h00C0);
        chk("R2 start kept", 32'(ctl_rd), 32'h00C2);
        wctl(16'h00C4);
        chk("R2 start cleared", 32'(ctl_rd), 32'h00C0);

        // R12 spare bit stored
        wctl(16'h00C8);
        chk("R12 readback", 32'(ctl_rd), 32'h00C8);
        // R10 priority, R5 word flag
        wctl(16'h00E1);
        chk("R10 hi_pri", 32'(hi_pri), 32'd1);
        chk("R5 word_xfer", 32'(word_xfer), 32'd1);
        wctl(16'h00C0);
        chk("R10 hi_pri low", 32'(hi_pri), 32'd0);

        // R7 free run ends at zero even with terminal bit clear
        setup(16'h0500, 20'h00200, 16'd2);
        tick();
        chk("R7 mid count", 32'(cnt_val), 32'd1);
        chk("R7 no early done", 32'(done), 32'd0);
        tick();
        chk("R7 done", 32'(done), 32'd1);
        chk("R9 no irq without tc", 32'(irq), 32'd0);
        chk("R7 start cleared", 32'(ctl_rd[1]), 32'd0);
        chk("R7 strobe low", 32'(xfer_stb), 32'd0);
        chk("R7 count zero", 32'(cnt_val), 32'd0);
        tick();
        chk("R7 done single", 32'(done), 32'd0);
        chk("R7 addr", 32'(src_addr), 32'h00202);

        // R8 synchronised with terminal count: ends, R9 irq fires
        setup(16'h0340, 20'h00300, 16'd1);
        src_req = 1'b1;
        tick();
        chk("R8 tc done", 32'(done), 32'd1);
        chk("R9 irq", 32'(irq), 32'd1);
        chk("R8 start cleared", 32'(ctl_rd[1]), 32'd0);
        tick();
        chk("R9 irq single", 32'(irq), 32'd0);
        src_req = 1'b0;

        // R8 synchronised without terminal count: wraps and continues
        setup(16'h0140, 20'h00300, 16'd1);
        src_req = 1'b1;
        tick();
        chk("R8 no done", 32'(done), 32'd0);
        chk("R8 count zero", 32'(cnt_val), 32'd0);
        chk("R8 still running", 32'(xfer_stb), 32'd1);
        tick();
        chk("R8 wrap", 32'(cnt_val), 32'hFFFF);
        halt();

        // R9 terminal count without interrupt bit
        setup(16'h0240, 20'h00300, 16'd1);
        src_req = 1'b1;
        tick();
        chk("R9 done", 32'(done), 32'd1);
        chk("R9 no irq", 32'(irq), 32'd0);
        src_req = 1'b0;

        // R11 stop write halts next cycle
        setup(16'h0400, 20'h00400, 16'd100);
        tick();
        chk("R11 running", 32'(xfer_stb), 32'd1);
        wctl(16'h0404);
        chk("R11 halted", 32'(xfer_stb), 32'd0);
        begin
            logic [CNT_W-1:0] snap;
            snap = cnt_val;
            tick();
            chk("R11 count holds", 32'(cnt_val), 32'(snap));
        end

        summary();
    end
endmodule